// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the byte-wide register side of an asynchronous serial port. A host reaches eight byte registers over a simple select/write bus: mode, bit rate, control, transmit data, status, receive data, and two extension registers. The block keeps the transmit and receive flags and the error bits. It drives four interrupt lines: receive, transmit, transmit-end and error. The bit-level serialiser is a separate framer. This block starts each character in the framer and is told when that character has finished. The framer hands received bytes and line-break events back to this block.

Transmit data waits in a one-deep queue. A byte written while the line is idle goes to the framer at once. A byte written while a character is in flight is held until that character finishes. Mode and bit-rate settings are frozen whenever the port is enabled. On an overrun the incoming byte is discarded and a sticky error interrupt is raised.

The receive path is a valid/ready stream. The framer presents `rx_byte` with `rx_valid` and must hold both until a cycle in which `rx_ready` is high. `rx_ready` follows the receive-enable bit, so a disabled port stalls the framer and loses nothing. While the port is enabled, every offered byte is taken at once: it is either stored or, on overrun, discarded. The transmit side is a plain strobe. The framer cannot refuse `tx_start`, and it reports the end of each character with a one-cycle `tx_done`.

Top module: `sio_reg_front`

## Requirements
- R1: The host registers sit at these byte offsets: mode at 0, bit rate at 1, control at 2, transmit data at 3, status at 4, receive data at 5, and extension registers at 6 and 7. The writable registers read back what was last written. In the control register, bit 7 enables the transmit interrupt, bit 6 enables the receive and error interrupts, bit 5 enables the transmitter, bit 4 enables the receiver, and bit 2 enables the transmit-end interrupt.
- R2: After reset the registers read as follows: mode 0x00, bit rate 0xFF, control 0x00, transmit data 0xFF, status 0x84, receive data 0x00, and both extension registers 0x00. All four interrupt lines are low after reset.
- R3: Writes to mode and bit rate have no effect while the transmitter enable or the receiver enable is set.
- R4: A control write with the transmitter enable set forces both the transmit-empty flag and the transmit-end flag to 1. The same write pulses the transmit interrupt if the new value enables it.
- R5: A control write that clears the transmit-end interrupt enable lowers the transmit-end interrupt. A control write that clears the receive interrupt enable lowers the error interrupt.
- R6: A transmit-data write while transmit-end is 1 starts a character at once: `tx_start` pulses with that byte on the next cycle. The start clears transmit-end, sets transmit-empty, lowers the transmit-end interrupt and pulses the transmit interrupt if enabled. A transmit-data write while transmit-end is 0 only clears transmit-empty, and the byte is held in the queue.
- R7: When `tx_done` arrives, a queued byte (transmit-empty = 0) is started next, with the same effects as in R6. If nothing is queued, transmit-end is set and the transmit-end interrupt goes high if it is enabled.
- R8: The status bits are: bit 7 transmit empty, bit 6 receive full, bit 5 overrun, bit 4 framing error, bit 3 parity error, bit 2 transmit end, bit 1 multiprocessor received (always 0), and bit 0 multiprocessor transmit. A host write changes only bits 0 and 3 to 5.
- R9: A status write that leaves all three error bits at 0 lowers the error interrupt, but only if the most recent status read showed an error bit set.
- R10: A byte accepted while receive-full is set is discarded: the receive data is unchanged and the overrun bit is set, and the error interrupt goes high if receive interrupts are enabled. Otherwise the byte is stored, receive-full is set, and the receive interrupt pulses if enabled.
- R11: Reading receive data clears receive-full. `rx_break` sets the framing-error bit and raises the error interrupt if receive interrupts are enabled.
- R12: A write to the receive-data offset has no effect.
- R13: The receive and transmit interrupts are pulses exactly one clock long. The error and transmit-end interrupts hold high until they are cleared as in R5, R6 and R9. `rx_ready` equals the receiver enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data (combinational, same cycle) |
| tx_start | output | 1 | One-cycle strobe that starts a character |
| tx_byte | output | 8 | Character to send, valid with tx_start |
| tx_done | input | 1 | Framer finished the current character |
| rx_valid | input | 1 | Framer offers a received byte |
| rx_ready | output | 1 | Byte accepted when high together with rx_valid |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Line break detected (one-cycle) |
| irq_rx | output | 1 | Receive interrupt pulse |
| irq_tx | output | 1 | Transmit interrupt pulse |
| irq_tend | output | 1 | Transmit-end interrupt level |
| irq_err | output | 1 | Error interrupt level |

## Verification
A transmit-end or transmit-empty flag in the wrong state shows on the next transmit-data write. That write either starts the framer when it should have queued, or queues when it should have started, and the difference is visible on `tx_start` one cycle later. A stale receive-full flag turns the next incoming byte into a spurious overrun, or lets it overwrite unread data. Either case shows on the error line at once and on the receive-data readback. A wrong record of the last status read surfaces only at the next status write, as an error interrupt that stays high or drops too early. The directed scenarios therefore sample every interrupt line and the status register right after each event.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int NREG = 1 << AW;

  localparam logic [AW-1:0] OFS_MODE  = 3'd0;
  localparam logic [AW-1:0] OFS_RATE  = 3'd1;
  localparam logic [AW-1:0] OFS_CTRL  = 3'd2;
  localparam logic [AW-1:0] OFS_TXD   = 3'd3;
  localparam logic [AW-1:0] OFS_STAT  = 3'd4;
  localparam logic [AW-1:0] OFS_RXD   = 3'd5;
  localparam logic [AW-1:0] OFS_EXTA  = 3'd6;
  localparam logic [AW-1:0] OFS_EXTB  = 3'd7;

  // control bit positions
  localparam int C_TXIE = 7;
  localparam int C_RXIE = 6;
  localparam int C_TXEN = 5;
  localparam int C_RXEN = 4;
  localparam int C_TEIE = 2;

  localparam logic [DW-1:0] RST_RATE = 8'hFF;
  localparam logic [DW-1:0] RST_TXD  = 8'hFF;
endpackage

// File: rtl/sio_tx_flags.sv
module sio_tx_flags
  import sio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          txie,
  input  logic          teie,
  input  logic          ctrl_wr,
  input  logic          new_txen,
  input  logic          new_txie,
  input  logic          new_teie,
  input  logic          txd_wr,
  input  logic [DW-1:0] wdata,
  input  logic          tx_done,
  output logic [DW-1:0] txd_q,
  output logic          tdre_q,
  output logic          tend_q,
  output logic          tx_start,
  output logic [DW-1:0] tx_byte,
  output logic          irq_tx,
  output logic          irq_tend
);
  logic          n_tdre, n_tend, n_tei, n_start, n_pulse;
  logic [DW-1:0] n_txd, n_byte;

  always_comb begin
    n_tdre  = tdre_q;
    n_tend  = tend_q;
    n_tei   = irq_tend;
    n_txd   = txd_q;
    n_byte  = txd_q;
    n_start = 1'b0;
    n_pulse = 1'b0;
    // character finished: send queued byte or go idle
    if (tx_done) begin
      if (!tdre_q) begin
        n_start = 1'b1;
        n_tend  = 1'b0;
        n_tdre  = 1'b1;
        n_tei   = 1'b0;
        n_pulse = txie;
      end else begin
        n_tend = 1'b1;
        if (teie) n_tei = 1'b1;
      end
    end
    // host writes transmit data: start when idle, else queue
    if (txd_wr) begin
      n_txd = wdata;
      if (n_tend) begin
        n_start = 1'b1;
        n_byte  = wdata;
        n_tend  = 1'b0;
        n_tdre  = 1'b1;
        n_tei   = 1'b0;
        n_pulse = n_pulse | txie;
      end else begin
        n_tdre = 1'b0;
      end
    end
    if (ctrl_wr) begin
      if (new_txen) begin
        n_tdre = 1'b1;
        n_tend = 1'b1;
        if (new_txie) n_pulse = 1'b1;
      end
      if (!new_teie) n_tei = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txd_q    <= RST_TXD;
      tdre_q   <= 1'b1;
      tend_q   <= 1'b1;
      tx_start <= 1'b0;
      tx_byte  <= '0;
      irq_tx   <= 1'b0;
      irq_tend <= 1'b0;
    end else begin
      txd_q    <= n_txd;
      tdre_q   <= n_tdre;
      tend_q   <= n_tend;
      tx_start <= n_start;
      tx_byte  <= n_start ? n_byte : tx_byte;
      irq_tx   <= n_pulse;
      irq_tend <= n_tei;
    end
  end

  assert_start_leaves_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> !tend_q);
  assert_tend_irq_has_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tend |-> tend_q);
endmodule

// File: rtl/sio_rx_flags.sv
module sio_rx_flags
  import sio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxen,
  input  logic          rxie,
  input  logic          ctrl_wr,
  input  logic          new_rxie,
  input  logic          stat_wr,
  input  logic          stat_rd,
  input  logic          rxd_rd,
  input  logic [2:0]    werr,
  input  logic          wmpbt,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_break,
  output logic          rx_ready,
  output logic [DW-1:0] rxd_q,
  output logic          rdrf_q,
  output logic [2:0]    err_q,   // {overrun, framing, parity}
  output logic          mpbt_q,
  output logic          irq_rx,
  output logic          irq_err
);
  logic          accept;
  logic          n_rdrf, n_eri, n_pulse, n_mpbt;
  logic [2:0]    n_err, last_err_q, n_last;
  logic [DW-1:0] n_rxd;

  assign rx_ready = rxen;
  assign accept   = rx_valid & rxen;

  always_comb begin
    n_rdrf  = rdrf_q;
    n_err   = err_q;
    n_eri   = irq_err;
    n_mpbt  = mpbt_q;
    n_rxd   = rxd_q;
    n_last  = last_err_q;
    n_pulse = 1'b0;
    if (rxd_rd)  n_rdrf = 1'b0;
    if (stat_rd) n_last = err_q;
    if (stat_wr) begin
      n_mpbt = wmpbt;
      n_err  = werr;
      if ((last_err_q != 3'b000) && (werr == 3'b000)) n_eri = 1'b0;
    end
    if (accept) begin
      if (n_rdrf) begin
        n_err[2] = 1'b1;
        if (rxie) n_eri = 1'b1;
      end else begin
        n_rxd   = rx_byte;
        n_rdrf  = 1'b1;
        n_pulse = rxie;
      end
    end
    if (rx_break) begin
      n_err[1] = 1'b1;
      if (rxie) n_eri = 1'b1;
    end
    if (ctrl_wr && !new_rxie) n_eri = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxd_q      <= '0;
      rdrf_q     <= 1'b0;
      err_q      <= '0;
      mpbt_q     <= 1'b0;
      last_err_q <= '0;
      irq_rx     <= 1'b0;
      irq_err    <= 1'b0;
    end else begin
      rxd_q      <= n_rxd;
      rdrf_q     <= n_rdrf;
      err_q      <= n_err;
      mpbt_q     <= n_mpbt;
      last_err_q <= n_last;
      irq_rx     <= n_pulse;
      irq_err    <= n_eri;
    end
  end

  assert_overrun_keeps_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rdrf_q && !rxd_rd) |=> ($stable(rxd_q) && err_q[2]));
  assert_read_clears_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rxd_rd && !accept) |=> !rdrf_q);
  assert_rx_pulse_has_data_R13: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> rdrf_q);
endmodule

// File: rtl/sio_reg_front.sv
module sio_reg_front
  import sio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          tx_start,
  output logic [DW-1:0] tx_byte,
  input  logic          tx_done,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_break,
  output logic          irq_rx,
  output logic          irq_tx,
  output logic          irq_tend,
  output logic          irq_err
);
  logic [NREG-1:0] wr_hit, rd_hit;
  logic [DW-1:0]   mode_q, rate_q, ctrl_q, exta_q, extb_q;
  logic [DW-1:0]   txd_q, rxd_q, status;
  logic            tdre_q, tend_q, rdrf_q, mpbt_q, locked;
  logic [2:0]      err_q;

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign wr_hit[i] = host_sel &  host_wr & (host_addr == AW'(i));
    assign rd_hit[i] = host_sel & ~host_wr & (host_addr == AW'(i));
  end

  assign locked = ctrl_q[C_TXEN] | ctrl_q[C_RXEN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      rate_q <= RST_RATE;
      ctrl_q <= '0;
      exta_q <= '0;
      extb_q <= '0;
    end else begin
      if (wr_hit[OFS_MODE] && !locked) mode_q <= host_wdata;
      if (wr_hit[OFS_RATE] && !locked) rate_q <= host_wdata;
      if (wr_hit[OFS_CTRL]) ctrl_q <= host_wdata;
      if (wr_hit[OFS_EXTA]) exta_q <= host_wdata;
      if (wr_hit[OFS_EXTB]) extb_q <= host_wdata;
    end
  end

  sio_tx_flags u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .txie     (ctrl_q[C_TXIE]),
    .teie     (ctrl_q[C_TEIE]),
    .ctrl_wr  (wr_hit[OFS_CTRL]),
    .new_txen (host_wdata[C_TXEN]),
    .new_txie (host_wdata[C_TXIE]),
    .new_teie (host_wdata[C_TEIE]),
    .txd_wr   (wr_hit[OFS_TXD]),
    .wdata    (host_wdata),
    .tx_done  (tx_done),
    .txd_q    (txd_q),
    .tdre_q   (tdre_q),
    .tend_q   (tend_q),
    .tx_start (tx_start),
    .tx_byte  (tx_byte),
    .irq_tx   (irq_tx),
    .irq_tend (irq_tend)
  );

  sio_rx_flags u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rxen     (ctrl_q[C_RXEN]),
    .rxie     (ctrl_q[C_RXIE]),
    .ctrl_wr  (wr_hit[OFS_CTRL]),
    .new_rxie (host_wdata[C_RXIE]),
    .stat_wr  (wr_hit[OFS_STAT]),
    .stat_rd  (rd_hit[OFS_STAT]),
    .rxd_rd   (rd_hit[OFS_RXD]),
    .werr     (host_wdata[5:3]),
    .wmpbt    (host_wdata[0]),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .rx_break (rx_break),
    .rx_ready (rx_ready),
    .rxd_q    (rxd_q),
    .rdrf_q   (rdrf_q),
    .err_q    (err_q),
    .mpbt_q   (mpbt_q),
    .irq_rx   (irq_rx),
    .irq_err  (irq_err)
  );

  assign status = {tdre_q, rdrf_q, err_q, tend_q, 1'b0, mpbt_q};

  always_comb begin
    unique case (host_addr)
      OFS_MODE: host_rdata = mode_q;
      OFS_RATE: host_rdata = rate_q;
      OFS_CTRL: host_rdata = ctrl_q;
      OFS_TXD:  host_rdata = txd_q;
      OFS_STAT: host_rdata = status;
      OFS_RXD:  host_rdata = rxd_q;
      OFS_EXTA: host_rdata = exta_q;
      default:  host_rdata = extb_q;
    endcase
  end

  assert_mode_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit[OFS_MODE] && locked) |=> $stable(mode_q));
  assert_rate_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit[OFS_RATE] && locked) |=> $stable(rate_q));
endmodule

// File: tb/test_sio_reg_front.sv
module test_sio_reg_front;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_sel = 1'b0, host_wr = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       tx_start;
  logic [7:0] tx_byte;
  logic       tx_done = 1'b0;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic [7:0] rx_byte = '0;
  logic       rx_break = 1'b0;
  logic       irq_rx, irq_tx, irq_tend, irq_err;
  int         n_checks = 0;
  int         n_fail = 0;

  always #5 clk = ~clk;

  sio_reg_front i_sio_reg_front (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_start(tx_start), .tx_byte(tx_byte), .tx_done(tx_done),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_byte(rx_byte),
    .rx_break(rx_break), .irq_rx(irq_rx), .irq_tx(irq_tx),
    .irq_tend(irq_tend), .irq_err(irq_err)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_sel = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic done_pulse();
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic brk();
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
  endtask

  task automatic t_reset();
    chk("R2 irqs", {4'b0, irq_rx, irq_tx, irq_tend, irq_err}, 8'h00);
    rd_chk("R2 mode", 3'd0, 8'h00);
    rd_chk("R2 rate", 3'd1, 8'hFF);
    rd_chk("R2 ctrl", 3'd2, 8'h00);
    rd_chk("R2 txd", 3'd3, 8'hFF);
    rd_chk("R2 status", 3'd4, 8'h84);
    rd_chk("R2 rxd", 3'd5, 8'h00);
    rd_chk("R2 exta", 3'd6, 8'h00);
    rd_chk("R2 extb", 3'd7, 8'h00);
  endtask

  task automatic t_map_lock();
    wr(3'd6, 8'h3A); wr(3'd7, 8'hC5);
    rd_chk("R1 exta", 3'd6, 8'h3A);
    rd_chk("R1 extb", 3'd7, 8'hC5);
    wr(3'd0, 8'h5A); wr(3'd1, 8'h40);
    rd_chk("R1 mode", 3'd0, 8'h5A);
    rd_chk("R1 rate", 3'd1, 8'h40);
    wr(3'd2, 8'h30);
    wr(3'd0, 8'h11); wr(3'd1, 8'h22);
    rd_chk("R3 mode locked", 3'd0, 8'h5A);
    rd_chk("R3 rate locked", 3'd1, 8'h40);
  endtask

  task automatic t_tx();
    wr(3'd2, 8'hA4);
    chk("R4 tx pulse", {7'b0, irq_tx}, 8'h01);
    rd_chk("R4 status", 3'd4, 8'h84);
    wr(3'd3, 8'h3C);
    chk("R6 start", {7'b0, tx_start}, 8'h01);
    chk("R6 byte", tx_byte, 8'h3C);
    chk("R6 tx pulse", {7'b0, irq_tx}, 8'h01);
    rd_chk("R6 status busy", 3'd4, 8'h80);
    wr(3'd3, 8'h55);
    chk("R6 queued no start", {7'b0, tx_start}, 8'h00);
    rd_chk("R6 status queued", 3'd4, 8'h00);
    done_pulse();
    chk("R7 queued start", {7'b0, tx_start}, 8'h01);
    chk("R7 queued byte", tx_byte, 8'h55);
    chk("R7 tx pulse", {7'b0, irq_tx}, 8'h01);
    chk("R7 tend low", {7'b0, irq_tend}, 8'h00);
    rd_chk("R7 status sending", 3'd4, 8'h80);
    done_pulse();
    chk("R7 tend irq", {7'b0, irq_tend}, 8'h01);
    rd_chk("R7 status idle", 3'd4, 8'h84);
    chk("R13 tend level holds", {7'b0, irq_tend}, 8'h01);
    wr(3'd3, 8'h99);
    chk("R6 start drops tend irq", {7'b0, irq_tend}, 8'h00);
    chk("R6 start again", {7'b0, tx_start}, 8'h01);
    rd_chk("R1 txd readback", 3'd3, 8'h99);
    done_pulse();
    chk("R7 tend irq again", {7'b0, irq_tend}, 8'h01);
    wr(3'd2, 8'hA0);
    chk("R5 teie clear drops", {7'b0, irq_tend}, 8'h00);
  endtask

  task automatic t_rx();
    wr(3'd2, 8'h50);
    chk("R13 ready on", {7'b0, rx_ready}, 8'h01);
    rx_send(8'hA5);
    chk("R10 rx pulse", {7'b0, irq_rx}, 8'h01);
    @(negedge clk);
    chk("R13 rx pulse one clock", {7'b0, irq_rx}, 8'h00);
    rd_chk("R10 status full", 3'd4, 8'hC4);
    rx_send(8'h11);
    chk("R10 overrun err irq", {7'b0, irq_err}, 8'h01);
    chk("R10 no rx pulse", {7'b0, irq_rx}, 8'h00);
    rd_chk("R10 status overrun", 3'd4, 8'hE4);
    rd_chk("R10 data kept", 3'd5, 8'hA5);
    rd_chk("R11 read clears full", 3'd4, 8'hA4);
    wr(3'd4, 8'hFF);
    rd_chk("R8 write mask", 3'd4, 8'hBD);
    chk("R9 err kept nonzero", {7'b0, irq_err}, 8'h01);
    wr(3'd4, 8'h00);
    chk("R9 err dropped", {7'b0, irq_err}, 8'h00);
    rd_chk("R8 status clean", 3'd4, 8'h84);
    brk();
    chk("R11 break err irq", {7'b0, irq_err}, 8'h01);
    wr(3'd4, 8'h00);
    chk("R9 no drop without error read", {7'b0, irq_err}, 8'h01);
    wr(3'd4, 8'h10);
    rd_chk("R11 framing bit", 3'd4, 8'h94);
    wr(3'd2, 8'h10);
    chk("R5 rie clear drops err", {7'b0, irq_err}, 8'h00);
    wr(3'd4, 8'h00);
    rx_send(8'h3E);
    chk("R10 no pulse when disabled", {7'b0, irq_rx}, 8'h00);
    rd_chk("R10 stored", 3'd5, 8'h3E);
    wr(3'd5, 8'h77);
    rd_chk("R12 rxd write ignored", 3'd5, 8'h3E);
    wr(3'd2, 8'h00);
    chk("R13 ready off", {7'b0, rx_ready}, 8'h00);
    rx_send(8'h66);
    rd_chk("R13 not accepted", 3'd5, 8'h3E);
    wr(3'd0, 8'h07);
    rd_chk("R3 unlocked", 3'd0, 8'h07);
  endtask

  initial begin
    #200000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map_lock();
    t_tx();
    t_rx();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule